// File: doc/BRIEF.md
# Snooping Write-Through Coherence Controller

This block gives each of several cores a small private data cache and keeps those caches coherent over one shared bus. Every store writes through to a shared backing memory, which is held inside the block. Loads that hit are served from the private cache without using the bus. Loads that miss, and all stores, compete for the bus through a round-robin arbiter. Exactly one transaction reaches the bus in any cycle.

Each cache watches every bus transaction that another core issues. A mode input selects the coherence policy:

- **Invalidate policy:** a store tells the other caches to drop any copy they hold. A store to a line that the writer knows it holds alone still writes memory, but it is marked as a quiet write that needs no snoop action.
- **Update policy:** every store carries its data to the other caches, and any matching copy is overwritten in place.

Under either policy, a load that follows a completed store never returns an older value.

A core drives a request with a valid flag and holds it until the block pulses ready for one cycle. On that cycle the load data is presented.

Top module: `snoop_wt_coherence`

## Requirements
- R1: After reset, no core sees ready, the bus is idle, and every memory word reads as zero.
- R2: A store writes the backing memory and the writer's own line in the same bus cycle. A later load by any core returns the stored value.
- R3: Under the invalidate policy (mode_update=0), a store that may have sharers is issued with bus command 1. Every other cache drops a matching valid line, so its next load of that address misses, uses the bus and returns the new value.
- R4: Under the update policy (mode_update=1), a store is issued with bus command 2. Every other cache holding the line overwrites its copy, so its next load of that address hits with no bus transaction and returns the new value.
- R5: Under the invalidate policy, a store to a line the writer holds as the only copy is issued with bus command 3. A line becomes the only copy through the writer's own invalidate-policy store, and loses that status as soon as another core reads it over the bus (command 0).
- R6: Under the update policy, every store is broadcast with command 2, including repeated stores to the same line.
- R7: Bus requests are granted round-robin, one transaction per cycle. When all cores request at once, the cores are granted in consecutive cycles and each is granted exactly once.
- R8: A load that hits, issued in the cycle another core's transaction on the bus targets the same cache index, waits until that transaction has been applied. It then returns the value that transaction left.
- R9: Each cache is direct-mapped with index = addr[2:0] and tag = addr[5:3]. A miss to the same index with a different tag replaces the line, and a later load of the evicted address misses again.
- R10: A load hit completes with ready one cycle after the request, with no bus transaction.
- R11: Ready is high for exactly one cycle per request, and rsp_data is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_update | input | 1 | 1 = update policy, 0 = invalidate policy |
| core_req_valid | input | N_CORES | Per-core request valid, held until ready |
| core_req_write | input | N_CORES | Per-core request is a store |
| core_req_addr | input | N_CORES*ADDR_W | Per-core word address, core i in slice i |
| core_req_wdata | input | N_CORES*DATA_W | Per-core store data |
| core_req_ready | output | N_CORES | One-cycle completion pulse per core |
| core_rsp_data | output | N_CORES*DATA_W | Load data, valid with ready |
| bus_valid | output | 1 | A transaction is on the shared bus this cycle |
| bus_cmd | output | 2 | 0 read fill, 1 store+invalidate, 2 store+update, 3 quiet store |
| bus_owner | output | OWN_W | Index of the core owning the bus |
| bus_addr | output | ADDR_W | Address of the bus transaction |

## Verification
The assertions check the following on every cycle:

- **Arbitration:** the grant is at most one requester and only one that is requesting; a core granted in one cycle loses the next grant when another core is waiting.
- **Snoop effects:** a matching line is dropped after an invalidating store and carries the broadcast data after an updating store; a quiet store never meets a valid copy in another cache.
- **Conflicts and handshake:** a conflicting load is held back; ready lasts one cycle; memory holds each written word.

Only the bench's scenarios can show the end-to-end ordering:

- a reader sees the newest write after a drop and refill or after an in-place update;
- sole-copy status is lost when another core reads the line;
- round-robin spreads four simultaneous stores over four consecutive cycles;
- a conflicting load returns the value of the store it overlapped.

// File: rtl/coh_pkg.sv
package coh_pkg;
   typedef enum logic [1:0] {
      CMD_READ     = 2'd0,
      CMD_WR_INV   = 2'd1,
      CMD_WR_UPD   = 2'd2,
      CMD_WR_QUIET = 2'd3
   } bus_cmd_t;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RESP = 1'b1
   } cache_st_t;
endpackage

// File: rtl/coh_rr_arbiter.sv
module coh_rr_arbiter #(
   parameter int N    = 4,
   parameter int IW   = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   output logic [N-1:0]  gnt,
   output logic [IW-1:0] gnt_idx
);
   generate
      if (N == 1) begin : g_single
         assign gnt     = req;
         assign gnt_idx = '0;
      end else begin : g_rr
         logic [IW-1:0] ptr;
         logic [N-1:0]  prev_gnt;
         logic          found;

         always_comb begin
            gnt     = '0;
            gnt_idx = '0;
            found   = 1'b0;
            for (int k = 0; k < N; k++) begin
               int c;
               c = (int'(ptr) + k) % N;
               if (!found && req[c]) begin
                  found   = 1'b1;
                  gnt[c]  = 1'b1;
                  gnt_idx = IW'(c);
               end
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ptr      <= '0;
               prev_gnt <= '0;
            end else begin
               prev_gnt <= gnt;
               if (|req)
                  ptr <= (int'(gnt_idx) == N - 1) ? '0 : gnt_idx + 1'b1;
            end
         end

         // R7: grant only to requesters, at most one per cycle
         a_r7_grant_subset: assert property (@(posedge clk) disable iff (!rst_n)
            ((gnt & ~req) == '0) && $onehot0(gnt));

         for (genvar i = 0; i < N; i++) begin : g_fair
            // R7: a core just served yields to any other waiting core
            a_r7_round_robin: assert property (@(posedge clk) disable iff (!rst_n)
               (prev_gnt[i] && ((req & ~(N'(1) << i)) != '0)) |-> !gnt[i]);
         end
      end
   endgenerate
endmodule

// File: rtl/coh_memory.sv
module coh_memory #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   assign rdata = mem[addr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_en) begin
         mem[addr] <= wdata;
      end
   end

   // R2: a write-through store lands in memory
   a_r2_mem_written: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (mem[$past(addr)] == $past(wdata)));
endmodule

// File: rtl/coh_cache.sv
module coh_cache
   import coh_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32,
   parameter int LINES  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_update,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic [DATA_W-1:0] rsp_data,
   output logic              bus_req,
   output bus_cmd_t          bus_cmd_o,
   input  logic              bus_gnt,
   input  logic              snp_valid,
   input  bus_cmd_t          snp_cmd,
   input  logic [ADDR_W-1:0] snp_addr,
   input  logic [DATA_W-1:0] snp_data,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int IDX_W = $clog2(LINES);
   localparam int TAG_W = ADDR_W - IDX_W;

   logic [TAG_W-1:0]  tag_a [LINES];
   logic [DATA_W-1:0] dat_a [LINES];
   logic [LINES-1:0]  vld;
   logic [LINES-1:0]  sole;
   cache_st_t         st;

   logic [IDX_W-1:0] req_idx, snp_idx;
   logic [TAG_W-1:0] req_tag, snp_tag;
   logic             hit, sole_hit, snp_hit, conflict, idle, load_local;

   assign req_idx  = req_addr[IDX_W-1:0];
   assign req_tag  = req_addr[ADDR_W-1:IDX_W];
   assign snp_idx  = snp_addr[IDX_W-1:0];
   assign snp_tag  = snp_addr[ADDR_W-1:IDX_W];

   assign hit      = vld[req_idx] && (tag_a[req_idx] == req_tag);
   assign sole_hit = hit && sole[req_idx];
   assign snp_hit  = snp_valid && vld[snp_idx] && (tag_a[snp_idx] == snp_tag);
   assign conflict = snp_valid && (snp_idx == req_idx);
   assign idle     = (st == ST_IDLE);

   assign load_local = idle && req_valid && !req_write && hit && !conflict;
   assign bus_req    = idle && req_valid && (req_write || !hit);

   always_comb begin
      if (!req_write)      bus_cmd_o = CMD_READ;
      else if (mode_update) bus_cmd_o = CMD_WR_UPD;
      else if (sole_hit)   bus_cmd_o = CMD_WR_QUIET;
      else                 bus_cmd_o = CMD_WR_INV;
   end

   assign req_ready = (st == ST_RESP);

   // handshake and response register
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         rsp_data <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (bus_gnt) begin
                  st       <= ST_RESP;
                  rsp_data <= req_write ? req_wdata : mem_rdata;
               end else if (load_local) begin
                  st       <= ST_RESP;
                  rsp_data <= dat_a[req_idx];
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // line state bits: own fills and stores first, snoops otherwise
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld  <= '0;
         sole <= '0;
      end else if (bus_gnt) begin
         vld[req_idx]  <= 1'b1;
         sole[req_idx] <= req_write && !mode_update;
      end else if (snp_hit) begin
         case (snp_cmd)
            CMD_READ:   sole[snp_idx] <= 1'b0;
            CMD_WR_INV: begin
               vld[snp_idx]  <= 1'b0;
               sole[snp_idx] <= 1'b0;
            end
            default: ;
         endcase
      end
   end

   // tag and data arrays carry no reset
   always_ff @(posedge clk) begin
      if (bus_gnt) begin
         tag_a[req_idx] <= req_tag;
         dat_a[req_idx] <= req_write ? req_wdata : mem_rdata;
      end else if (snp_hit && snp_cmd == CMD_WR_UPD) begin
         dat_a[snp_idx] <= snp_data;
      end
   end

   // R3: an invalidating store drops the matching copy
   a_r3_inv_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_hit && snp_cmd == CMD_WR_INV) |=> !vld[$past(snp_idx)]);

   // R4: an updating store overwrites the matching copy
   a_r4_upd_overwrites: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_hit && snp_cmd == CMD_WR_UPD) |=> (dat_a[$past(snp_idx)] == $past(snp_data)));

   // R5: a quiet store never finds a copy in another cache
   a_r5_quiet_unshared: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && snp_cmd == CMD_WR_QUIET) |-> !snp_hit);

   // R8: a load colliding with a snooped index is not answered next cycle
   a_r8_conflict_waits: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && req_valid && !req_write && !bus_gnt && conflict) |=> !req_ready);

   // R11: ready is a single-cycle pulse
   a_r11_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |=> !req_ready);
endmodule

// File: rtl/snoop_wt_coherence.sv
module snoop_wt_coherence
   import coh_pkg::*;
#(
   parameter int N_CORES = 4,
   parameter int ADDR_W  = 6,
   parameter int DATA_W  = 32,
   parameter int LINES   = 8,
   parameter int OWN_W   = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      mode_update,
   input  logic [N_CORES-1:0]        core_req_valid,
   input  logic [N_CORES-1:0]        core_req_write,
   input  logic [N_CORES*ADDR_W-1:0] core_req_addr,
   input  logic [N_CORES*DATA_W-1:0] core_req_wdata,
   output logic [N_CORES-1:0]        core_req_ready,
   output logic [N_CORES*DATA_W-1:0] core_rsp_data,
   output logic                      bus_valid,
   output logic [1:0]                bus_cmd,
   output logic [OWN_W-1:0]          bus_owner,
   output logic [ADDR_W-1:0]         bus_addr
);
   localparam int IDX_W = $clog2(LINES);

   generate
      if (N_CORES < 1) begin : g_bad_cores
         $error("N_CORES must be at least 1");
      end
      if (LINES < 2 || (1 << IDX_W) != LINES) begin : g_bad_lines
         $error("LINES must be a power of two, at least 2");
      end
      if (IDX_W >= ADDR_W) begin : g_bad_addr
         $error("ADDR_W must exceed the index width");
      end
   endgenerate

   logic [N_CORES-1:0] breq, gnt;
   bus_cmd_t           c_cmd [N_CORES];
   bus_cmd_t           sel_cmd;
   logic [ADDR_W-1:0]  sel_addr;
   logic [DATA_W-1:0]  sel_data;
   logic [DATA_W-1:0]  mem_rdata;

   coh_rr_arbiter #(.N(N_CORES), .IW(OWN_W)) u_arb (
      .clk(clk), .rst_n(rst_n), .req(breq), .gnt(gnt), .gnt_idx(bus_owner));

   always_comb begin
      sel_cmd  = CMD_READ;
      sel_addr = '0;
      sel_data = '0;
      for (int i = 0; i < N_CORES; i++) begin
         if (gnt[i]) begin
            sel_cmd  = c_cmd[i];
            sel_addr = core_req_addr[i*ADDR_W +: ADDR_W];
            sel_data = core_req_wdata[i*DATA_W +: DATA_W];
         end
      end
   end

   assign bus_valid = |gnt;
   assign bus_cmd   = sel_cmd;
   assign bus_addr  = sel_addr;

   coh_memory #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
      .clk(clk), .rst_n(rst_n),
      .wr_en(bus_valid && sel_cmd != CMD_READ),
      .addr(sel_addr), .wdata(sel_data), .rdata(mem_rdata));

   for (genvar i = 0; i < N_CORES; i++) begin : g_cache
      coh_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_cache (
         .clk(clk), .rst_n(rst_n), .mode_update(mode_update),
         .req_valid(core_req_valid[i]),
         .req_write(core_req_write[i]),
         .req_addr(core_req_addr[i*ADDR_W +: ADDR_W]),
         .req_wdata(core_req_wdata[i*DATA_W +: DATA_W]),
         .req_ready(core_req_ready[i]),
         .rsp_data(core_rsp_data[i*DATA_W +: DATA_W]),
         .bus_req(breq[i]), .bus_cmd_o(c_cmd[i]), .bus_gnt(gnt[i]),
         .snp_valid(bus_valid && !gnt[i]),
         .snp_cmd(sel_cmd), .snp_addr(sel_addr), .snp_data(sel_data),
         .mem_rdata(mem_rdata));
   end

   // R7: one owner whenever the bus is busy
   a_r7_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> $onehot(gnt));

   // R5: quiet stores exist only under the invalidate policy
   a_r5_quiet_policy: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && sel_cmd == CMD_WR_QUIET) |-> !mode_update);

   // R1: nothing completes or uses the bus in the first cycle after reset
   a_r1_quiet_start: assert property (@(posedge clk)
      !rst_n |=> (core_req_ready == '0));
endmodule

// File: tb/snoop_wt_coherence_bench.sv
`timescale 1ns/1ps
module snoop_wt_coherence_bench;
   localparam int N  = 4;
   localparam int AW = 6;
   localparam int DW = 32;
   localparam logic [1:0] C_READ = 2'd0, C_INV = 2'd1, C_UPD = 2'd2, C_QUIET = 2'd3;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic              rst_n, mode_update;
   logic [N-1:0]      v, w, rdy;
   logic [AW-1:0]     a [N];
   logic [DW-1:0]     d [N];
   logic [N*AW-1:0]   f_addr;
   logic [N*DW-1:0]   f_wdata, f_rsp;
   logic              bus_valid;
   logic [1:0]        bus_cmd;
   logic [1:0]        bus_owner;
   logic [AW-1:0]     bus_addr;

   always_comb begin
      for (int c = 0; c < N; c++) begin
         f_addr[c*AW +: AW]  = a[c];
         f_wdata[c*DW +: DW] = d[c];
      end
   end

   snoop_wt_coherence u_snoop_wt_coherence (
      .clk(clk), .rst_n(rst_n), .mode_update(mode_update),
      .core_req_valid(v), .core_req_write(w), .core_req_addr(f_addr),
      .core_req_wdata(f_wdata), .core_req_ready(rdy), .core_rsp_data(f_rsp),
      .bus_valid(bus_valid), .bus_cmd(bus_cmd), .bus_owner(bus_owner),
      .bus_addr(bus_addr));

   int checks = 0, errors = 0, cyc = 0;
   logic [DW-1:0] shadow [64];
   logic [DW-1:0] exp_d [N][$];
   string         exp_r [N][$];
   bit            is_ld [N];
   logic [1:0]    last_cmd [N];
   int            bus_seen [N], lat [N], done_cyc [N];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(bit ok, string r, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
      end
   endtask

   // driver: issue one request, push expectation, wait for ready
   task automatic op(int c, bit wr, logic [AW-1:0] addr, logic [DW-1:0] data,
                     string r, bit ovr = 1'b0, logic [DW-1:0] ov = '0);
      @(negedge clk);
      v[c] = 1'b1; w[c] = wr; a[c] = addr; d[c] = data;
      is_ld[c] = !wr;
      if (!wr) begin
         exp_d[c].push_back(ovr ? ov : shadow[addr]);
         exp_r[c].push_back(r);
      end
      bus_seen[c] = 0; lat[c] = 0;
      do begin
         #1;
         if (bus_valid && int'(bus_owner) == c) begin
            bus_seen[c]++;
            last_cmd[c] = bus_cmd;
         end
         @(negedge clk);
         lat[c]++;
      end while (!rdy[c]);
      v[c] = 1'b0;
      done_cyc[c] = cyc;
      if (wr) shadow[addr] = data;
   endtask

   // monitor: compares load responses against the scoreboard
   always @(negedge clk) begin
      for (int c = 0; c < N; c++) begin
         if (rst_n && rdy[c] && is_ld[c]) begin
            if (exp_d[c].size() == 0) begin
               check(1'b0, "R11", "unexpected load response", f_rsp[c*DW +: DW], '0);
            end else begin
               logic [DW-1:0] e;
               string r;
               e = exp_d[c].pop_front();
               r = exp_r[c].pop_front();
               check(f_rsp[c*DW +: DW] == e, r, "load data", f_rsp[c*DW +: DW], e);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) shadow[i] = '0;
      for (int c = 0; c < N; c++) begin
         a[c] = '0; d[c] = '0; is_ld[c] = 1'b0; last_cmd[c] = '0;
      end
      v = '0; w = '0; mode_update = 1'b0; rst_n = 1'b0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: idle after reset, memory reads as zero
      check(rdy == '0, "R1", "ready after reset", 32'(rdy), 0);
      check(!bus_valid, "R1", "bus idle after reset", 32'(bus_valid), 0);
      op(2, 0, 6'd5, 0, "R1");

      // R2: write-through store, then readers on both sides
      op(0, 1, 6'd10, 32'hA1, "R2");
      check(last_cmd[0] == C_INV, "R3", "first store cmd", 32'(last_cmd[0]), 32'(C_INV));
      op(1, 0, 6'd10, 0, "R2");
      check(bus_seen[1] == 1 && last_cmd[1] == C_READ, "R2", "miss fill on bus", 32'(bus_seen[1]), 1);
      op(0, 0, 6'd10, 0, "R10");
      check(bus_seen[0] == 0, "R10", "hit uses no bus", 32'(bus_seen[0]), 0);
      check(lat[0] == 1, "R10", "hit latency", 32'(lat[0]), 1);
      @(negedge clk);
      check(rdy[0] == 1'b0, "R11", "ready dropped after one cycle", 32'(rdy[0]), 0);

      // R3: invalidate of a shared copy forces a refill
      op(0, 1, 6'd10, 32'hB2, "R3");
      check(last_cmd[0] == C_INV, "R3", "shared store cmd", 32'(last_cmd[0]), 32'(C_INV));
      op(1, 0, 6'd10, 0, "R3");
      check(bus_seen[1] == 1, "R3", "reader refilled", 32'(bus_seen[1]), 1);

      // R5: sole copy stores go quiet until someone reads
      op(2, 1, 6'd20, 32'hC3, "R5");
      check(last_cmd[2] == C_INV, "R5", "first store cmd", 32'(last_cmd[2]), 32'(C_INV));
      op(2, 1, 6'd20, 32'hC4, "R5");
      check(last_cmd[2] == C_QUIET, "R5", "repeat store cmd", 32'(last_cmd[2]), 32'(C_QUIET));
      op(3, 0, 6'd20, 0, "R5");
      op(2, 1, 6'd20, 32'hC5, "R5");
      check(last_cmd[2] == C_INV, "R5", "store after remote read", 32'(last_cmd[2]), 32'(C_INV));
      op(3, 0, 6'd20, 0, "R5");

      // R4 and R6: update policy overwrites copies in place
      mode_update = 1'b1;
      op(0, 0, 6'd33, 0, "R4");
      op(1, 0, 6'd33, 0, "R4");
      op(0, 1, 6'd33, 32'hD1, "R4");
      check(last_cmd[0] == C_UPD, "R4", "update store cmd", 32'(last_cmd[0]), 32'(C_UPD));
      op(1, 0, 6'd33, 0, "R4");
      check(bus_seen[1] == 0, "R4", "updated copy hits", 32'(bus_seen[1]), 0);
      op(0, 1, 6'd33, 32'hD2, "R6");
      check(last_cmd[0] == C_UPD, "R6", "repeat store still broadcast", 32'(last_cmd[0]), 32'(C_UPD));
      op(1, 0, 6'd33, 0, "R6");
      check(bus_seen[1] == 0, "R6", "second update hits", 32'(bus_seen[1]), 0);

      // R9: same index, other tag evicts (33 and 41 share index 1)
      op(1, 0, 6'd41, 0, "R9");
      check(bus_seen[1] == 1, "R9", "other tag misses", 32'(bus_seen[1]), 1);
      op(1, 0, 6'd33, 0, "R9");
      check(bus_seen[1] == 1, "R9", "evicted line misses", 32'(bus_seen[1]), 1);

      // R7: four simultaneous stores are served round-robin
      mode_update = 1'b0;
      fork
         op(0, 1, 6'd48, 32'hE0, "R7");
         op(1, 1, 6'd49, 32'hE1, "R7");
         op(2, 1, 6'd50, 32'hE2, "R7");
         op(3, 1, 6'd51, 32'hE3, "R7");
      join
      begin
         int mn, mx;
         bit distinct;
         mn = done_cyc[0]; mx = done_cyc[0]; distinct = 1'b1;
         for (int c = 0; c < N; c++) begin
            if (done_cyc[c] < mn) mn = done_cyc[c];
            if (done_cyc[c] > mx) mx = done_cyc[c];
            for (int k = c + 1; k < N; k++)
               if (done_cyc[c] == done_cyc[k]) distinct = 1'b0;
            check(bus_seen[c] == 1, "R7", "one grant per core", 32'(bus_seen[c]), 1);
         end
         check(distinct, "R7", "one transaction per cycle", 32'(distinct), 1);
         check(mx - mn == 3, "R7", "consecutive grants", 32'(mx - mn), 3);
      end
      for (int c = 0; c < N; c++) op((c + 1) % N, 0, 6'(48 + c), 0, "R7");

      // R8: load hit colliding with a store on the same index
      op(1, 0, 6'd60, 0, "R8");
      fork
         op(0, 1, 6'd60, 32'hF1, "R8");
         op(1, 0, 6'd60, 0, "R8", 1'b1, 32'hF1);
      join
      check(lat[1] == 2, "R8", "colliding load waited", 32'(lat[1]), 2);
      check(bus_seen[1] == 1, "R8", "colliding load refilled", 32'(bus_seen[1]), 1);

      repeat (3) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule